// File: doc/BRIEF.md
# Chainable Up-Counting Timer with Trigger Linking

This block is a 16-bit up-counting timer. It has a programmable clock divider, a reload limit, one compare channel and a trigger output that can be selected. A companion timer's trigger output wires straight into this timer's trigger input. Through that link, one timer can act as the clock of another, where the second timer counts the first one's update pulses. One timer can also act as the enable of another, where the second timer counts only while the first one's compare waveform is high. Long time bases and windowed counts are built by cascading instances.

Software programs the block through a single-cycle synchronous write port and a registered read port. The counter runs from zero up to the reload value and then wraps. The cycle after each wrap carries a one-cycle update pulse. At each update, buffered reload and compare values move into the working copies. In one-shot mode the run bit drops at the first update.

Top module: `link_timer`

Register addresses: 0 control (bit0 run, bit1 one-shot, bit2 reload buffered, bit3 compare buffered); 1 mode (bits 2:0 trigger-out select, 5:3 link mode, 8:6 trigger source, 11:9 compare mode); 2 divider; 3 reload; 4 compare; 5 count.

## Requirements
- R1: After reset the reload register reads 0xFFFF and every other register reads 0. The outputs trig_out, cmp_out and upd_evt are all 0.
- R2: With link mode 000, the counter advances once every DIV+1 cycles while run is 1. A reload value N gives one update pulse every (N+1)*(DIV+1) cycles.
- R3: upd_evt is high for one cycle: the cycle after the counter steps from the reload value to 0.
- R4: The compare-mode code selects cmp_out. Code 110 is high while count < compare. Code 111 is the inverse of 110. Code 101 is forced high. Code 100 and all other codes are low. cmp_out lags the count by one cycle.
- R5: When control bit1 is 1, the update clears the run bit and the count stays at 0, so exactly one update occurs.
- R6: With control bit2 (or bit3) set, a written reload (or compare) value takes effect only at the next update. With the bit clear, it takes effect at once.
- R7: The trigger-out select code chooses trig_out. Code 001 gives the run bit, 010 the update pulse (in the same cycle as upd_evt), and 100 the compare waveform (equal to cmp_out). All other codes give 0.
- R8: Link mode 111 advances the divider once per rising edge of the selected trigger, that is, in a cycle where the trigger is 1 and was 0 in the previous cycle.
- R9: Link mode 101 advances the divider only in cycles where the selected trigger is 1.
- R10: Trigger source 000 selects trig_in. Any other source code gives a constant-low trigger.
- R11: A software write to the count in the same cycle the counter would wrap loads the written value and produces no update pulse.
- R12: While run is 0, the count holds its value.
- R13: Reads return the addressed register one cycle after the address. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| trig_in | input | 1 | Trigger from a linked timer, same clock domain |
| trig_out | output | 1 | Selected trigger output |
| cmp_out | output | 1 | Compare waveform |
| upd_evt | output | 1 | One-cycle update pulse |

## Verification
A software write to the count and the counter's own wrap can fall on the same clock edge. The bench provokes this with the divider at 1 and reload 7. It waits for an update pulse and then times a count write so it lands exactly on the edge where the count sits at 7. The collision is judged correct when no update pulse follows that edge and the next pulse arrives six cycles later, the time the written value 2 needs to climb to 7 and wrap. A second instance drives the trigger input, so the divider-by-edges and gated behaviour are judged by counted updates and count differences over windows whose length is a whole number of trigger periods.

// File: rtl/link_timer_pkg.sv
package link_timer_pkg;

  localparam int REG_AW = 3;
  typedef logic [REG_AW-1:0] reg_adr_t;

  localparam reg_adr_t ADR_CTRL = 3'd0;
  localparam reg_adr_t ADR_MODE = 3'd1;
  localparam reg_adr_t ADR_DIV  = 3'd2;
  localparam reg_adr_t ADR_RLD  = 3'd3;
  localparam reg_adr_t ADR_CMP  = 3'd4;
  localparam reg_adr_t ADR_CNT  = 3'd5;

  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] sel_t;

  // trigger-out selection
  localparam sel_t TOUT_RUN = 3'b001;
  localparam sel_t TOUT_UPD = 3'b010;
  localparam sel_t TOUT_REF = 3'b100;

  // link (slave) behaviour
  localparam sel_t LINK_GATE = 3'b101;
  localparam sel_t LINK_EDGE = 3'b111;

  // trigger source
  localparam sel_t TSRC_PEER = 3'b000;

  // compare waveform
  localparam sel_t WAVE_LOW  = 3'b100;
  localparam sel_t WAVE_HIGH = 3'b101;
  localparam sel_t WAVE_PWM1 = 3'b110;
  localparam sel_t WAVE_PWM2 = 3'b111;

  typedef struct packed {
    logic cmp_buf;
    logic rld_buf;
    logic one_shot;
    logic run;
  } ctrl_t;

  typedef struct packed {
    sel_t wave;
    sel_t tsrc;
    sel_t link;
    sel_t tout;
  } mode_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/link_timer_regs.sv
module link_timer_regs
  import link_timer_pkg::*;
#(
  parameter int CNT_W = 16  // must be at least MODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_adr_t         addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_val,
  output ctrl_t            ctrl,
  output mode_t            mode,
  output logic [CNT_W-1:0] div,
  output logic [CNT_W-1:0] rld_shadow,
  output logic [CNT_W-1:0] cmp_shadow,
  output logic             rld_we,
  output logic             cmp_we,
  output logic             cnt_we,
  output logic [CNT_W-1:0] rdata
);

  logic             wr_ctrl, wr_mode, wr_div;
  logic [CNT_W-1:0] rd_next;

  assign wr_ctrl = wr_en && (addr == ADR_CTRL);
  assign wr_mode = wr_en && (addr == ADR_MODE);
  assign wr_div  = wr_en && (addr == ADR_DIV);
  assign rld_we  = wr_en && (addr == ADR_RLD);
  assign cmp_we  = wr_en && (addr == ADR_CMP);
  assign cnt_we  = wr_en && (addr == ADR_CNT);

  always_comb begin
    rd_next = '0;
    case (addr)
      ADR_CTRL: rd_next[CTRL_W-1:0] = ctrl;
      ADR_MODE: rd_next[MODE_W-1:0] = mode;
      ADR_DIV:  rd_next = div;
      ADR_RLD:  rd_next = rld_shadow;
      ADR_CMP:  rd_next = cmp_shadow;
      ADR_CNT:  rd_next = cnt_val;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      mode       <= '0;
      div        <= '0;
      rld_shadow <= '1;
      cmp_shadow <= '0;
      rdata      <= '0;
    end else begin
      if (wr_ctrl)
        ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (wrap && ctrl.one_shot)
        ctrl.run <= 1'b0;
      if (wr_mode) mode <= mode_t'(wdata[MODE_W-1:0]);
      if (wr_div)  div <= wdata;
      if (rld_we)  rld_shadow <= wdata;
      if (cmp_we)  cmp_shadow <= wdata;
      rdata <= rd_next;
    end
  end

  // R5
  one_shot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && ctrl.one_shot && !wr_ctrl) |=> !ctrl.run);

  // R13
  rd_div_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == ADR_DIV) |=> (rdata == $past(div)));

endmodule

// File: rtl/link_timer_core.sv
module link_timer_core
  import link_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rld_buf,
  input  logic             cmp_buf,
  input  sel_t             link,
  input  sel_t             tsrc,
  input  logic [CNT_W-1:0] div,
  input  logic [CNT_W-1:0] rld_shadow,
  input  logic [CNT_W-1:0] cmp_shadow,
  input  logic             rld_we,
  input  logic             cmp_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             trig_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act,
  output logic             wrap,
  output logic             upd_evt
);

  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             trig_sel, trig_q, trig_rise;
  logic             link_en, raw_en, tick;
  logic [CNT_W-1:0] presc, rld_act;

  assign trig_sel  = (tsrc == TSRC_PEER) ? trig_in : 1'b0;
  assign trig_rise = trig_sel & ~trig_q;

  always_comb begin
    case (link)
      LINK_EDGE: link_en = trig_rise;
      LINK_GATE: link_en = trig_sel;
      default:   link_en = 1'b1;
    endcase
  end

  assign raw_en = run & link_en;
  // a divider lowered mid-count releases at once
  assign tick   = raw_en && (presc >= div);
  assign wrap   = tick && !cnt_we && (cnt == rld_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= 1'b0;
      presc   <= '0;
      cnt     <= '0;
      rld_act <= '1;
      cmp_act <= '0;
      upd_evt <= 1'b0;
    end else begin
      trig_q  <= trig_sel;
      upd_evt <= wrap;
      if (raw_en)
        presc <= tick ? '0 : presc + STEP;
      if (cnt_we)
        cnt <= wdata;
      else if (tick)
        cnt <= wrap ? '0 : cnt + STEP;
      if (rld_we && !rld_buf)
        rld_act <= wdata;
      else if (wrap)
        rld_act <= rld_shadow;
      if (cmp_we && !cmp_buf)
        cmp_act <= wdata;
      else if (wrap)
        cmp_act <= cmp_shadow;
    end
  end

  // R3
  upd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    upd_evt |-> (cnt == '0));

  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> ((cnt == $past(wdata)) && !upd_evt));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt));

  // R8
  edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((link == LINK_EDGE) && !trig_rise && !cnt_we) |=> $stable(cnt));

  // R9
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((link == LINK_GATE) && !trig_sel && !cnt_we) |=> $stable(cnt));

endmodule

// File: rtl/link_timer_out.sv
module link_timer_out
  import link_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  input  sel_t             wave,
  input  sel_t             tout,
  input  logic             run,
  input  logic             wrap,
  output logic             cmp_out,
  output logic             trig_out
);

  logic below, ref_now, trg_now;

  assign below = (cnt < cmp_act);

  always_comb begin
    case (wave)
      WAVE_PWM1: ref_now = below;
      WAVE_PWM2: ref_now = ~below;
      WAVE_HIGH: ref_now = 1'b1;
      default:   ref_now = 1'b0;
    endcase
  end

  always_comb begin
    case (tout)
      TOUT_RUN: trg_now = run;
      TOUT_UPD: trg_now = wrap;
      TOUT_REF: trg_now = ref_now;
      default:  trg_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_out  <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      cmp_out  <= ref_now;
      trig_out <= trg_now;
    end
  end

  // R4
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wave == WAVE_LOW) |=> !cmp_out);

  // R7
  trig_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (tout == TOUT_REF) |=> (trig_out == cmp_out));

endmodule

// File: rtl/link_timer.sv
module link_timer
  import link_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             trig_in,
  output logic             trig_out,
  output logic             cmp_out,
  output logic             upd_evt
);

  ctrl_t            ctrl;
  mode_t            mode;
  logic [CNT_W-1:0] div, rld_shadow, cmp_shadow, cnt, cmp_act;
  logic             rld_we, cmp_we, cnt_we, wrap;

  link_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .wrap       (wrap),
    .cnt_val    (cnt),
    .ctrl       (ctrl),
    .mode       (mode),
    .div        (div),
    .rld_shadow (rld_shadow),
    .cmp_shadow (cmp_shadow),
    .rld_we     (rld_we),
    .cmp_we     (cmp_we),
    .cnt_we     (cnt_we),
    .rdata      (rdata)
  );

  link_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl.run),
    .rld_buf    (ctrl.rld_buf),
    .cmp_buf    (ctrl.cmp_buf),
    .link       (mode.link),
    .tsrc       (mode.tsrc),
    .div        (div),
    .rld_shadow (rld_shadow),
    .cmp_shadow (cmp_shadow),
    .rld_we     (rld_we),
    .cmp_we     (cmp_we),
    .cnt_we     (cnt_we),
    .wdata      (wdata),
    .trig_in    (trig_in),
    .cnt        (cnt),
    .cmp_act    (cmp_act),
    .wrap       (wrap),
    .upd_evt    (upd_evt)
  );

  link_timer_out #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .cmp_act  (cmp_act),
    .wave     (mode.wave),
    .tout     (mode.tout),
    .run      (ctrl.run),
    .wrap     (wrap),
    .cmp_out  (cmp_out),
    .trig_out (trig_out)
  );

endmodule

// File: tb/tb_link_timer.sv
module tb_link_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_DIV = 3'd2,
                         A_RLD = 3'd3, A_CMP = 3'd4, A_CNT = 3'd5;

  // div, reload, compare, wave code, expected high cycles per period
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 7, 5, 6, 5},
    '{2, 4, 2, 6, 6},
    '{0, 9, 0, 6, 0},
    '{1, 5, 6, 6, 12},
    '{0, 7, 3, 7, 5},
    '{3, 3, 2, 6, 8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic d_we = 1'b0, f_we = 1'b0;
  logic [2:0] d_addr = '0, f_addr = '0;
  logic [15:0] d_wdata = '0, f_wdata = '0;
  logic [15:0] d_rdata, f_rdata;
  logic d_trig, d_cmp, upd_evt, f_trig, f_cmp, f_upd;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_timer dut (
    .clk(clk), .rst(rst), .wr_en(d_we), .addr(d_addr), .wdata(d_wdata),
    .rdata(d_rdata), .trig_in(f_trig), .trig_out(d_trig), .cmp_out(d_cmp),
    .upd_evt(upd_evt)
  );

  link_timer feeder (
    .clk(clk), .rst(rst), .wr_en(f_we), .addr(f_addr), .wdata(f_wdata),
    .rdata(f_rdata), .trig_in(1'b0), .trig_out(f_trig), .cmp_out(f_cmp),
    .upd_evt(f_upd)
  );

  function automatic logic [15:0] mw(input logic [2:0] tout, input logic [2:0] link,
                                     input logic [2:0] tsrc, input logic [2:0] wave);
    return {4'b0000, wave, tsrc, link, tout};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_d(input logic [2:0] a, input logic [15:0] v);
    d_addr = a; d_wdata = v; d_we = 1'b1;
    @(negedge clk);
    d_we = 1'b0;
  endtask

  task automatic wr_f(input logic [2:0] a, input logic [15:0] v);
    f_addr = a; f_wdata = v; f_we = 1'b1;
    @(negedge clk);
    f_we = 1'b0;
  endtask

  task automatic rd_d(input logic [2:0] a, output int v);
    d_addr = a;
    @(negedge clk);
    v = int'(d_rdata);
  endtask

  task automatic wait_upd(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!upd_evt && gap < 2000);
  endtask

  task automatic window(input int n, output int highs, output int upds, output int ftr);
    highs = 0; upds = 0; ftr = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      highs += int'(d_cmp);
      upds  += int'(upd_evt);
      ftr   += int'(f_trig);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired before the sequence completed");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, g, hi, up, ft, v0, v1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cmp_out", int'(d_cmp), 0);
    chk("R1 trig_out", int'(d_trig), 0);
    chk("R1 upd_evt", int'(upd_evt), 0);
    rd_d(A_RLD, v);  chk("R1 reload", v, 16'hFFFF);
    rd_d(A_CNT, v);  chk("R1 count", v, 0);
    rd_d(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd_d(A_MODE, v); chk("R1 mode", v, 0);

    // R13 readback
    wr_d(A_CMP, 16'h1234);
    rd_d(A_CMP, v); chk("R13 compare readback", v, 16'h1234);
    rd_d(3'd7, v);  chk("R13 unused address", v, 0);

    // vector table: R2 period and R4 waveform
    for (int i = 0; i < NV; i++) begin
      int per;
      per = (VEC[i][1] + 1) * (VEC[i][0] + 1);
      wr_d(A_CTRL, 16'd0);
      wr_d(A_CNT, 16'd0);
      wr_d(A_DIV, 16'(VEC[i][0]));
      wr_d(A_RLD, 16'(VEC[i][1]));
      wr_d(A_CMP, 16'(VEC[i][2]));
      wr_d(A_MODE, mw(3'b000, 3'b000, 3'b000, 3'(VEC[i][3])));
      wr_d(A_CTRL, 16'd1);
      repeat (2 * per) @(negedge clk);
      window(3 * per, hi, up, ft);
      chk($sformatf("R4 vector %0d high cycles", i), hi, 3 * VEC[i][4]);
      chk($sformatf("R2 vector %0d update count", i), up, 3);
    end

    // R5 one-shot
    wr_d(A_CTRL, 16'd0);
    wr_d(A_CNT, 16'd0);
    wr_d(A_DIV, 16'd0);
    wr_d(A_RLD, 16'd4);
    wr_d(A_MODE, 16'd0);
    wr_d(A_CTRL, 16'd3);
    window(30, hi, up, ft);
    chk("R5 single update", up, 1);
    rd_d(A_CTRL, v); chk("R5 run cleared", v, 2);
    rd_d(A_CNT, v);  chk("R5 count parked", v, 0);

    // R12 hold while stopped
    wr_d(A_CTRL, 16'd0);
    wr_d(A_CNT, 16'd5);
    repeat (20) @(negedge clk);
    rd_d(A_CNT, v); chk("R12 count held", v, 5);

    // R6 buffered reload
    wr_d(A_CNT, 16'd0);
    wr_d(A_RLD, 16'd9);
    wr_d(A_CTRL, 16'd5);
    wait_upd(g);
    wr_d(A_RLD, 16'd3);
    wait_upd(g);
    chk("R6 buffered old period", g + 1, 10);
    wait_upd(g);
    chk("R6 buffered new period", g, 4);

    // R6 unbuffered reload
    wr_d(A_CTRL, 16'd1);
    wait_upd(g);
    wr_d(A_RLD, 16'd6);
    wait_upd(g);
    chk("R6 immediate period", g + 1, 7);

    // R11 count write on the wrap edge
    wr_d(A_CTRL, 16'd0);
    wr_d(A_CNT, 16'd0);
    wr_d(A_RLD, 16'd7);
    wr_d(A_CTRL, 16'd1);
    wait_upd(g);
    repeat (7) @(negedge clk);
    wr_d(A_CNT, 16'd2);
    chk("R11 no update on collision", int'(upd_evt), 0);
    wait_upd(g);
    chk("R11 period from written value", g, 6);

    // R8 and R7: feeder update pulses clock the dut
    wr_d(A_CTRL, 16'd0);
    wr_f(A_CTRL, 16'd0);
    wr_f(A_CNT, 16'd0);
    wr_f(A_DIV, 16'd3);
    wr_f(A_RLD, 16'd4);
    wr_f(A_MODE, mw(3'b010, 3'b000, 3'b000, 3'b000));
    wr_d(A_CNT, 16'd0);
    wr_d(A_DIV, 16'd0);
    wr_d(A_RLD, 16'd2);
    wr_d(A_MODE, mw(3'b000, 3'b111, 3'b000, 3'b000));
    wr_f(A_CTRL, 16'd1);
    wr_d(A_CTRL, 16'd1);
    repeat (120) @(negedge clk);
    window(240, hi, up, ft);
    chk("R7 update pulses on trig_out", ft, 12);
    chk("R8 edge-clocked updates", up, 4);

    // R9 and R7: feeder compare waveform gates the dut
    wr_f(A_CTRL, 16'd0);
    wr_f(A_CNT, 16'd0);
    wr_f(A_DIV, 16'd0);
    wr_f(A_RLD, 16'd9);
    wr_f(A_CMP, 16'd4);
    wr_f(A_MODE, mw(3'b100, 3'b000, 3'b000, 3'b110));
    wr_d(A_CTRL, 16'd0);
    wr_d(A_CNT, 16'd0);
    wr_d(A_RLD, 16'hFFFF);
    wr_d(A_MODE, mw(3'b000, 3'b101, 3'b000, 3'b000));
    wr_f(A_CTRL, 16'd1);
    wr_d(A_CTRL, 16'd1);
    repeat (20) @(negedge clk);
    d_addr = A_CNT;
    @(negedge clk);
    v0 = int'(d_rdata);
    window(100, hi, up, ft);
    v1 = int'(d_rdata);
    chk("R9 gated count", v1 - v0, 40);
    chk("R7 compare waveform on trig_out", ft, 40);

    // R10 non-peer trigger source
    wr_d(A_MODE, mw(3'b000, 3'b101, 3'b001, 3'b000));
    d_addr = A_CNT;
    @(negedge clk);
    v0 = int'(d_rdata);
    repeat (100) @(negedge clk);
    v1 = int'(d_rdata);
    chk("R10 other source stays low", v1 - v0, 0);

    // R7 run level and unused code
    wr_f(A_MODE, mw(3'b001, 3'b000, 3'b000, 3'b000));
    @(negedge clk);
    chk("R7 run level on trig_out", int'(f_trig), 1);
    wr_f(A_MODE, mw(3'b011, 3'b000, 3'b000, 3'b000));
    @(negedge clk);
    chk("R7 unused code low", int'(f_trig), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule